// File: doc/BRIEF.md
# Shared-Buffer Output Contention Scheduler

This block makes the per-slot forwarding decision for an N-by-N packet switch. The switch has a few zero-delay bypass lanes and a set of feed-forward shared storage modules. Each clock is one time slot. On every slot the scheduler looks at the destinations of the packets that arrive on its inputs. For each output it picks the packet to transmit. It sends every other arriving packet either into storage or to the drop path. It keeps the number of stored packets per output and in total.

Stored packets always take precedence over fresh arrivals. A bypass lane is used only for an output that has nothing in storage. Two limits bound admission to storage: a cap per output (the smaller of the total storage size and the circulation limit) and a cap on total storage. A separate per-output queue records the source input of each stored packet, so packets leave in the order they arrived. The decision for the arrivals sampled at a clock edge appears on the outputs directly after that edge.

Top module: `sbs_sched`

## Requirements
- R1: While reset is held, and on the first slot after it, every fate is 0, no transmit is valid, all occupancies are 0, and both counters are 0.
- R2: An output whose occupancy is nonzero at the start of a slot transmits its oldest stored packet in that slot, with tx_buf set. No arrival for that output is given a bypass lane.
- R3: A bypass lane goes only to an output with zero occupancy that has at least one arrival. At most N_DIRECT lanes are granted per slot, and they are handed out in ascending output index.
- R4: Fates are reported per input as 2-bit codes: 0 no arrival, 1 sent on a bypass lane, 2 stored, 3 dropped. For an output that gets a lane, the arrival with the lowest input index takes it. The other arrivals for that output compete for storage.
- R5: The occupancy of an output never exceeds min(N_MOD*MOD_SLOTS, CIRC_LIMIT).
- R6: The total occupancy never exceeds N_MOD*MOD_SLOTS, and it always equals the sum of the per-output occupancies.
- R7: Stored packets for an output leave in arrival order. Packets stored in the same slot leave in ascending input index.
- R8: An arrival that can get neither a lane nor a storage place gets fate 3. drop_cnt grows by the number of such arrivals.
- R9: Storage admission uses the occupancy that remains after this slot's read. A full output still admits one arrival in a slot in which it transmits.
- R10: At most N_MOD*MOD_PORTS arrivals are stored per slot. Counting from 0 in ascending input order, the k-th stored arrival is assigned module k / MOD_PORTS.
- R11: Each output sends at most one packet per slot. tx_cnt grows by the number of valid transmits.
- R12: Input i uses arr_dest bits [i*SW +: SW], fate bits [2i +: 2] and fate_mod bits [i*MW +: MW]. Output o uses tx_src bits [o*SW +: SW] and occ bits [o*CW +: CW]. Every result shows on the outputs after the clock edge that samples the arrivals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arr_valid | input | N_PORTS | Arrival present per input |
| arr_dest | input | N_PORTS*SW | Destination output per input |
| fate | output | 2*N_PORTS | Per-input outcome code |
| fate_mod | output | N_PORTS*MW | Storage module assigned to a stored arrival |
| tx_valid | output | N_PORTS | Output transmits this slot |
| tx_src | output | N_PORTS*SW | Source input of the transmitted packet |
| tx_buf | output | N_PORTS | Transmitted packet came from storage |
| occ | output | N_PORTS*CW | Stored packets per output |
| occ_total | output | TW | Stored packets in total |
| drop_cnt | output | 32 | Running count of dropped arrivals |
| tx_cnt | output | 32 | Running count of transmitted packets |

## Verification
A directed burst of three arrivals for one empty output separates the lowest-index lane winner from the stored followers. The slots that follow show that a stored packet beats a newer arrival and that the queue keeps its order. Four arrivals for four empty outputs show the lane limit and the ascending grant order. Seven arrivals for one output make the per-output cap bind while write ports are still free. The next slot tests read-then-write reuse of a full output. A broadcast to a third output then makes the total cap bind on its own. Several hundred random slots at mixed load follow, and every field is compared against a slot-level reference model in the bench.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
   typedef enum logic [1:0] {
      FATE_NONE   = 2'd0,
      FATE_DIRECT = 2'd1,
      FATE_BUFFER = 2'd2,
      FATE_DROP   = 2'd3
   } fate_e;

   function automatic int smin(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

   function automatic int wbits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/sbs_admit.sv
module sbs_admit
   import sbs_pkg::*;
#(
   parameter int N_PORTS   = 8,
   parameter int N_DIRECT  = 2,
   parameter int MOD_PORTS = 3,
   parameter int OUT_CAP   = 5,
   parameter int TOT_CAP   = 8,
   parameter int WR_PORTS  = 6,
   parameter int SW        = 3,
   parameter int CW        = 3,
   parameter int TW        = 4,
   parameter int MW        = 1
) (
   input  logic [N_PORTS-1:0]               arr_valid,
   input  logic [N_PORTS-1:0][SW-1:0]       arr_dest,
   input  logic [N_PORTS-1:0][CW-1:0]       occ,
   input  logic [TW-1:0]                    occ_total,
   output logic [N_PORTS-1:0][1:0]          fate,
   output logic [N_PORTS-1:0][MW-1:0]       mod_sel,
   output logic [N_PORTS-1:0]               rd_en,
   output logic [N_PORTS-1:0]               dir_grant,
   output logic [N_PORTS-1:0][SW-1:0]       dir_src,
   output logic [N_PORTS-1:0][N_PORTS-1:0]  push
);
   int lvl_w [N_PORTS];
   int tot_w;
   int ports_w;
   int rd_w;
   int d_w;

   // read side: every non-empty output drains its head this slot
   always_comb begin
      for (int o = 0; o < N_PORTS; o++) rd_en[o] = (occ[o] != '0);
   end

   // bypass lanes: ascending output order, lowest input wins
   if (N_DIRECT > 0) begin : g_direct
      always_comb begin
         int  used;
         bit  hit;
         used = 0;
         for (int o = 0; o < N_PORTS; o++) begin
            dir_grant[o] = 1'b0;
            dir_src[o]   = '0;
            hit          = 1'b0;
            for (int i = N_PORTS - 1; i >= 0; i--) begin
               if (arr_valid[i] && int'(arr_dest[i]) == o) begin
                  hit        = 1'b1;
                  dir_src[o] = SW'(i);
               end
            end
            if (hit && occ[o] == '0 && used < N_DIRECT) begin
               dir_grant[o] = 1'b1;
               used         = used + 1;
            end
         end
      end
   end else begin : g_no_direct
      assign dir_grant = '0;
      assign dir_src   = '0;
   end

   // storage admission in ascending input order, after this slot's reads
   always_comb begin
      rd_w = 0;
      for (int o = 0; o < N_PORTS; o++) begin
         lvl_w[o] = int'(occ[o]) - (rd_en[o] ? 1 : 0);
         if (rd_en[o]) rd_w = rd_w + 1;
      end
      tot_w   = int'(occ_total) - rd_w;
      ports_w = 0;
      d_w     = 0;
      push    = '0;
      fate    = '0;
      mod_sel = '0;
      for (int i = 0; i < N_PORTS; i++) begin
         if (arr_valid[i]) begin
            d_w = int'(arr_dest[i]);
            if (dir_grant[d_w] && int'(dir_src[d_w]) == i) begin
               fate[i] = FATE_DIRECT;
            end else if (lvl_w[d_w] < OUT_CAP && tot_w < TOT_CAP &&
                         ports_w < WR_PORTS) begin
               fate[i]        = FATE_BUFFER;
               mod_sel[i]     = MW'(ports_w / MOD_PORTS);
               push[d_w][i]   = 1'b1;
               lvl_w[d_w]     = lvl_w[d_w] + 1;
               tot_w          = tot_w + 1;
               ports_w        = ports_w + 1;
            end else begin
               fate[i] = FATE_DROP;
            end
         end
      end
   end
endmodule

// File: rtl/sbs_out_fifo.sv
module sbs_out_fifo #(
   parameter int N_SRC = 8,
   parameter int DEPTH = 5,
   parameter int SW    = 3,
   parameter int CW    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pop,
   input  logic [N_SRC-1:0] push_mask,
   output logic [SW-1:0]    head,
   output logic [CW-1:0]    count
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [SW-1:0] mem_q [DEPTH];
   logic [SW-1:0] mem_n [DEPTH];
   logic [PW-1:0] rp_q, wp_q, wp_n, rp_n;
   logic [CW-1:0] cnt_q, cnt_n;

   function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
      return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
   endfunction

   // several same-slot pushes land in ascending source order
   always_comb begin
      mem_n = mem_q;
      wp_n  = wp_q;
      for (int i = 0; i < N_SRC; i++) begin
         if (push_mask[i]) begin
            mem_n[wp_n] = SW'(i);
            wp_n        = bump(wp_n);
         end
      end
      rp_n  = pop ? bump(rp_q) : rp_q;
      cnt_n = cnt_q - CW'(pop) + CW'($countones(push_mask));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
         rp_q  <= '0;
         wp_q  <= '0;
         cnt_q <= '0;
      end else begin
         mem_q <= mem_n;
         rp_q  <= rp_n;
         wp_q  <= wp_n;
         cnt_q <= cnt_n;
      end
   end

   assign head  = mem_q[rp_q];
   assign count = cnt_q;

   p_fifo_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt_q) <= DEPTH)
      else $error("output queue above its cap");

   p_pop_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> cnt_q != '0)
      else $error("read from empty output queue");
endmodule

// File: rtl/sbs_sched.sv
module sbs_sched
   import sbs_pkg::*;
#(
   parameter int N_PORTS    = 8,
   parameter int N_DIRECT   = 2,
   parameter int N_MOD      = 2,
   parameter int MOD_PORTS  = 3,
   parameter int MOD_SLOTS  = 4,
   parameter int CIRC_LIMIT = 5,
   localparam int SW       = wbits(N_PORTS),
   localparam int TOT_CAP  = N_MOD * MOD_SLOTS,
   localparam int OUT_CAP  = smin(TOT_CAP, CIRC_LIMIT),
   localparam int WR_PORTS = N_MOD * MOD_PORTS,
   localparam int K_MID    = N_DIRECT + WR_PORTS,
   localparam int CW       = $clog2(OUT_CAP + 1),
   localparam int TW       = $clog2(TOT_CAP + 1),
   localparam int MW       = wbits(N_MOD)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_PORTS-1:0]      arr_valid,
   input  logic [N_PORTS*SW-1:0]   arr_dest,
   output logic [2*N_PORTS-1:0]    fate,
   output logic [N_PORTS*MW-1:0]   fate_mod,
   output logic [N_PORTS-1:0]      tx_valid,
   output logic [N_PORTS*SW-1:0]   tx_src,
   output logic [N_PORTS-1:0]      tx_buf,
   output logic [N_PORTS*CW-1:0]   occ,
   output logic [TW-1:0]           occ_total,
   output logic [31:0]             drop_cnt,
   output logic [31:0]             tx_cnt
);
   initial begin
      assert ((1 << SW) == N_PORTS) else $error("N_PORTS must be a power of two");
      assert (MOD_PORTS <= MOD_SLOTS) else $error("module ports exceed module slots");
      assert (K_MID >= 1) else $error("middle stage is empty");
      assert (CIRC_LIMIT >= 1) else $error("circulation limit must be positive");
   end

   logic [N_PORTS-1:0][SW-1:0]      dest_p;
   logic [N_PORTS-1:0][CW-1:0]      occ_p;
   logic [N_PORTS-1:0][SW-1:0]      head_p;
   logic [N_PORTS-1:0][1:0]         fate_c, fate_q;
   logic [N_PORTS-1:0][MW-1:0]      mod_c, mod_q;
   logic [N_PORTS-1:0]              rd_en, dir_grant;
   logic [N_PORTS-1:0][SW-1:0]      dir_src;
   logic [N_PORTS-1:0][N_PORTS-1:0] push;
   logic [N_PORTS-1:0]              txv_q, txb_q;
   logic [N_PORTS-1:0][SW-1:0]      txs_q;
   logic [TW-1:0]                   total_q;
   logic [31:0]                     drop_q, txc_q;
   int n_wr, n_drop, n_rd, n_tx, occ_sum;

   assign dest_p = arr_dest;

   sbs_admit #(
      .N_PORTS(N_PORTS), .N_DIRECT(N_DIRECT), .MOD_PORTS(MOD_PORTS),
      .OUT_CAP(OUT_CAP), .TOT_CAP(TOT_CAP), .WR_PORTS(WR_PORTS),
      .SW(SW), .CW(CW), .TW(TW), .MW(MW)
   ) u_admit (
      .arr_valid(arr_valid), .arr_dest(dest_p), .occ(occ_p),
      .occ_total(total_q), .fate(fate_c), .mod_sel(mod_c), .rd_en(rd_en),
      .dir_grant(dir_grant), .dir_src(dir_src), .push(push)
   );

   for (genvar o = 0; o < N_PORTS; o++) begin : g_out
      sbs_out_fifo #(
         .N_SRC(N_PORTS), .DEPTH(OUT_CAP), .SW(SW), .CW(CW)
      ) u_fifo (
         .clk(clk), .rst_n(rst_n), .pop(rd_en[o]), .push_mask(push[o]),
         .head(head_p[o]), .count(occ_p[o])
      );

      p_direct_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
         dir_grant[o] |-> occ_p[o] == '0)
         else $error("bypass granted to output with stored packets");

      p_buffer_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
         occ_p[o] != '0 |=> tx_valid[o] && tx_buf[o])
         else $error("stored packet not sent first");
   end

   always_comb begin
      n_wr    = 0;
      n_drop  = 0;
      n_rd    = 0;
      n_tx    = 0;
      occ_sum = 0;
      for (int i = 0; i < N_PORTS; i++) begin
         if (fate_c[i] == FATE_BUFFER) n_wr = n_wr + 1;
         if (fate_c[i] == FATE_DROP)   n_drop = n_drop + 1;
         if (rd_en[i]) n_rd = n_rd + 1;
         if (rd_en[i] || dir_grant[i]) n_tx = n_tx + 1;
         occ_sum = occ_sum + int'(occ_p[i]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fate_q  <= '0;
         mod_q   <= '0;
         txv_q   <= '0;
         txb_q   <= '0;
         txs_q   <= '0;
         total_q <= '0;
         drop_q  <= '0;
         txc_q   <= '0;
      end else begin
         fate_q  <= fate_c;
         mod_q   <= mod_c;
         txv_q   <= rd_en | dir_grant;
         txb_q   <= rd_en;
         for (int o = 0; o < N_PORTS; o++)
            txs_q[o] <= rd_en[o] ? head_p[o] : dir_src[o];
         total_q <= TW'(int'(total_q) - n_rd + n_wr);
         drop_q  <= drop_q + 32'(n_drop);
         txc_q   <= txc_q + 32'(n_tx);
      end
   end

   assign fate      = fate_q;
   assign fate_mod  = mod_q;
   assign tx_valid  = txv_q;
   assign tx_buf    = txb_q;
   assign tx_src    = txs_q;
   assign occ       = occ_p;
   assign occ_total = total_q;
   assign drop_cnt  = drop_q;
   assign tx_cnt    = txc_q;

   p_total_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      int'(total_q) <= TOT_CAP)
      else $error("total storage above capacity");

   p_total_sum_r6: assert property (@(posedge clk) disable iff (!rst_n)
      int'(total_q) == occ_sum)
      else $error("total disagrees with per-output queues");

   p_direct_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(dir_grant) <= N_DIRECT)
      else $error("too many bypass lanes granted");

   p_wr_ports_r10: assert property (@(posedge clk) disable iff (!rst_n)
      n_wr <= WR_PORTS)
      else $error("too many storage writes in one slot");

   p_drop_mono_r8: assert property (@(posedge clk) disable iff (!rst_n)
      n_drop > 0 |=> drop_cnt > $past(drop_cnt))
      else $error("drop counter did not advance");
endmodule

// File: tb/tb_sbs_sched.sv
`timescale 1ns/1ps
module tb_sbs_sched;
   localparam int N    = 8;
   localparam int NDIR = 2;
   localparam int NMOD = 2;
   localparam int MP   = 3;
   localparam int MS   = 4;
   localparam int CL   = 5;
   localparam int SW   = 3;
   localparam int TOT  = NMOD * MS;
   localparam int OCAP = (TOT < CL) ? TOT : CL;
   localparam int WP   = NMOD * MP;
   localparam int CW   = $clog2(OCAP + 1);
   localparam int TW   = $clog2(TOT + 1);
   localparam int MW   = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] arr_valid = '0;
   logic [N*SW-1:0] arr_dest = '0;
   logic [2*N-1:0] fate;
   logic [N*MW-1:0] fate_mod;
   logic [N-1:0] tx_valid, tx_buf;
   logic [N*SW-1:0] tx_src;
   logic [N*CW-1:0] occ;
   logic [TW-1:0] occ_total;
   logic [31:0] drop_cnt, tx_cnt;

   always #5 clk = ~clk;

   sbs_sched #(.N_PORTS(N), .N_DIRECT(NDIR), .N_MOD(NMOD), .MOD_PORTS(MP),
               .MOD_SLOTS(MS), .CIRC_LIMIT(CL)) dut (
      .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_dest(arr_dest),
      .fate(fate), .fate_mod(fate_mod), .tx_valid(tx_valid), .tx_src(tx_src),
      .tx_buf(tx_buf), .occ(occ), .occ_total(occ_total),
      .drop_cnt(drop_cnt), .tx_cnt(tx_cnt));

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   int mq [N][8];
   int mlen [N];
   int mtot, mdrop, mtx;
   int e_fate [N], e_mod [N], e_txv [N], e_txs [N], e_txb [N];
   int sv [N], sd [N];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int o = 0; o < N; o++) mlen[o] = 0;
      mtot = 0; mdrop = 0; mtx = 0;
   endtask

   // slot-level reference derived from R2..R11
   task automatic model_step();
      int pre [N];
      int dwin [N];
      int used, rd, ports, d;
      rd = 0;
      for (int o = 0; o < N; o++) begin
         pre[o] = mlen[o]; dwin[o] = -1;
         e_txv[o] = 0; e_txs[o] = 0; e_txb[o] = 0;
         if (mlen[o] > 0) begin
            e_txv[o] = 1; e_txb[o] = 1; e_txs[o] = mq[o][0];
            for (int k = 0; k < 7; k++) mq[o][k] = mq[o][k+1];
            mlen[o]--; rd++; mtx++;
         end
      end
      used = 0;
      for (int o = 0; o < N; o++) begin
         if (pre[o] == 0 && used < NDIR) begin
            for (int i = N - 1; i >= 0; i--)
               if (sv[i] != 0 && sd[i] == o) dwin[o] = i;
            if (dwin[o] >= 0) begin
               used++; mtx++;
               e_txv[o] = 1; e_txs[o] = dwin[o]; e_txb[o] = 0;
            end
         end
      end
      mtot -= rd;
      ports = 0;
      for (int i = 0; i < N; i++) begin
         e_fate[i] = 0; e_mod[i] = 0;
         if (sv[i] != 0) begin
            d = sd[i];
            if (dwin[d] == i) e_fate[i] = 1;
            else if (mlen[d] < OCAP && mtot < TOT && ports < WP) begin
               e_fate[i] = 2; e_mod[i] = ports / MP;
               mq[d][mlen[d]] = i; mlen[d]++; mtot++; ports++;
            end else begin
               e_fate[i] = 3; mdrop++;
            end
         end
      end
   endtask

   task automatic compare();
      int a;
      for (int i = 0; i < N; i++) begin
         a = int'(fate[2*i +: 2]);
         chk(a == e_fate[i], "R4 R8 fate", a, e_fate[i]);
         if (e_fate[i] == 2) begin
            a = int'(fate_mod[i*MW +: MW]);
            chk(a == e_mod[i], "R10 module", a, e_mod[i]);
         end
      end
      for (int o = 0; o < N; o++) begin
         chk(int'(tx_valid[o]) == e_txv[o], "R3 R11 tx_valid", int'(tx_valid[o]), e_txv[o]);
         if (e_txv[o] != 0) begin
            a = int'(tx_src[o*SW +: SW]);
            chk(a == e_txs[o], "R7 tx_src", a, e_txs[o]);
            chk(int'(tx_buf[o]) == e_txb[o], "R2 tx_buf", int'(tx_buf[o]), e_txb[o]);
         end
         a = int'(occ[o*CW +: CW]);
         chk(a == mlen[o], "R5 R9 occ", a, mlen[o]);
      end
      chk(int'(occ_total) == mtot, "R6 total", int'(occ_total), mtot);
      chk(int'(drop_cnt) == mdrop, "R8 drop_cnt", int'(drop_cnt), mdrop);
      chk(int'(tx_cnt) == mtx, "R11 tx_cnt", int'(tx_cnt), mtx);
   endtask

   // R12: drive before the edge, read results just after it
   task automatic slot();
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
         arr_valid[i] = (sv[i] != 0);
         arr_dest[i*SW +: SW] = SW'(sd[i]);
      end
      model_step();
      @(posedge clk);
      #1;
      compare();
   endtask

   task automatic clear_stim();
      for (int i = 0; i < N; i++) begin sv[i] = 0; sd[i] = 0; end
   endtask

   task automatic idle(input int n);
      clear_stim();
      for (int k = 0; k < n; k++) slot();
   endtask

   task automatic check_reset_state();
      chk(fate == '0, "R1 fate", int'(fate), 0);
      chk(tx_valid == '0, "R1 tx_valid", int'(tx_valid), 0);
      chk(occ == '0, "R1 occ", int'(occ), 0);
      chk(occ_total == '0, "R1 total", int'(occ_total), 0);
      chk(drop_cnt == 0 && tx_cnt == 0, "R1 counters", int'(drop_cnt + tx_cnt), 0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      arr_valid = '0;
      repeat (3) @(posedge clk);
      #1;
      check_reset_state();
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      @(posedge clk);
      #1;
      check_reset_state();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      model_reset();
      clear_stim();
      do_reset();

      // R4: inputs 5,2,7 to empty output 0 -> 2 bypass, 5 and 7 stored
      clear_stim();
      sv[5] = 1; sd[5] = 0; sv[2] = 1; sd[2] = 0; sv[7] = 1; sd[7] = 0;
      slot();
      // R2: newer arrival on input 0 is stored while 5 leaves
      clear_stim(); sv[0] = 1; sd[0] = 0;
      slot();
      // R7: then 7, then 0
      idle(3);

      // R3: four empty outputs, two lanes -> outputs 0 and 1 win
      clear_stim();
      for (int i = 0; i < 4; i++) begin sv[i] = 1; sd[i] = 3 - i; end
      slot();
      idle(3);

      // R5: seven arrivals for output 0 -> one bypass, five stored, one dropped
      do_reset();
      clear_stim();
      for (int i = 0; i < 7; i++) begin sv[i] = 1; sd[i] = 0; end
      slot();
      // R9: full output sends one and admits one
      clear_stim(); sv[0] = 1; sd[0] = 0; sv[1] = 1; sd[1] = 0;
      slot();
      // R6: broadcast to output 2 until the total cap binds
      clear_stim();
      for (int i = 0; i < N; i++) begin sv[i] = 1; sd[i] = 2; end
      slot();
      idle(8);

      // random mixed load
      for (int s = 0; s < 400; s++) begin
         int load;
         load = (s < 200) ? 50 : 85;
         for (int i = 0; i < N; i++) begin
            sv[i] = (($urandom % 100) < load) ? 1 : 0;
            sd[i] = (s % 3 == 0) ? int'($urandom % 3) : int'($urandom % N);
         end
         slot();
      end
      idle(10);

      do_reset();
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule